// File: doc/BRIEF.md
# Polyphase Interpolating Complex FIR Filter

This block raises the sample rate of a complex (I/Q) stream by an integer factor L and filters it with an N-tap FIR response. The result is the same as stuffing L-1 zeros between input samples and filtering at the high rate. The work is split into L phases of T = N/L taps each, so every multiply uses a real input sample and never a stuffed zero. One multiplier per rail walks the taps of the current phase sequentially. Each accumulated sum is rounded, scaled by a coarse power of two and saturated to 16 bits.

Coefficients sit in a 128-entry memory grouped by phase. An offset register picks where the active filter starts, so several short responses can share the memory and be switched between input blocks. Recent input samples are held in a 16-deep circular data memory per rail. Reset clears neither memory, so software zeroes the data memory through the configuration write port before first use.

Configuration write port: `cfg_sel_i` 0 selects registers, 1 selects coefficients, 2 selects data memory. Register 0 holds N-1 (bits 6:0), register 1 holds T-1 (bits 3:0), register 2 holds the coefficient offset O (bits 6:0), and register 3 holds the scale s (bits 2:0). A coefficient write puts `cfg_data_i[15:0]` (two's complement, Q15) at address `cfg_addr_i`. A data write puts I from bits 15:0 and Q from bits 31:16 into entry `cfg_addr_i[3:0]`.

Top module: `pp_interp_fir`

## Requirements
- R1: While rst_ni is low and after it rises, in_ready_o is 1, out_valid_o is 0, out_i_o and out_q_o are 0, and the registers hold N=1, T=1, O=0, s=0.
- R2: A sample (16-bit two's complement I and Q) is taken on a clock edge where in_valid_i and in_ready_o are both 1. in_ready_o is 0 from the next cycle until the cycle of that sample's last output.
- R3: Each accepted sample x[n] yields L = N/T outputs, for phases p = 0 to L-1 in order. Output p accumulates C[(O + p*T + k) mod 128] * x[n-k] over k = 0 to T-1, which equals zero-stuffing followed by the FIR h[k*L+p]. N must equal T*L.
- R4: Coefficient reads start at offset O and wrap modulo 128. Changing O between samples switches to another filter stored in the same memory.
- R5: The data memory keeps the last 16 samples per rail. A data write sets one entry on both rails. Reset clears neither the data memory nor the coefficient memory.
- R6: With accumulator A and scale s (0 to 7), the output is floor((A + 2^(14-s)) / 2^(15-s)), which is rounding half up.
- R7: Results above 32767 give 32767, and results below -32768 give -32768.
- R8: Output j (counted from 0) of a sample has out_valid_o high for exactly one cycle, after the (j+1)*(T+1)-th clock edge following acceptance. out_i_o and out_q_o hold their values between pulses.
- R9: The I and Q rails use the same coefficients, and each rail uses only its own input history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Target: 0 registers, 1 coefficients, 2 data memory |
| cfg_addr_i | input | 7 | Register index, coefficient address or data entry |
| cfg_data_i | input | 32 | Write data |
| in_valid_i | input | 1 | Input sample present |
| in_i_i | input | 16 | Input I sample |
| in_q_i | input | 16 | Input Q sample |
| in_ready_o | output | 1 | Filter idle, sample can be taken |
| out_valid_o | output | 1 | Output sample strobe |
| out_i_o | output | 16 | Output I sample |
| out_q_o | output | 16 | Output Q sample |

## Verification
The assertions assume three things about the inputs. The registers change only while in_ready_o is high, N is an exact multiple of T, and the scale stays within 0 to 7. Under these conditions the number of output strobes per sample, multiplied by T, comes back to N. The bench writes configuration only between samples and picks L so that T*L never exceeds 128. It checks every output against a software model of the zero-stuffed filter, and it checks the cycle of every strobe.

// File: rtl/pp_fir_pkg.sv
package pp_fir_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MAC  = 2'd1,
    ST_EMIT = 2'd2
  } fir_state_e;

  localparam logic [1:0] SEL_REG  = 2'd0;
  localparam logic [1:0] SEL_COEF = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  localparam int REG_NTAPS = 0;
  localparam int REG_TPP   = 1;
  localparam int REG_OFF   = 2;
  localparam int REG_SCALE = 3;
endpackage

// File: rtl/pp_fir_cfg.sv
module pp_fir_cfg
  import pp_fir_pkg::*;
#(
  parameter int CA_W = 7,
  parameter int DA_W = 4,
  parameter int SC_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [CA_W-1:0] addr_i,
  input  logic [CA_W-1:0] data_i,
  output logic [CA_W-1:0] ntaps_m1_o,
  output logic [DA_W-1:0] tpp_m1_o,
  output logic [CA_W-1:0] coef_off_o,
  output logic [SC_W-1:0] scale_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ntaps_m1_o <= '0;
      tpp_m1_o   <= '0;
      coef_off_o <= '0;
      scale_o    <= '0;
    end else if (we_i) begin
      if (addr_i == CA_W'(REG_NTAPS)) ntaps_m1_o <= data_i;
      if (addr_i == CA_W'(REG_TPP))   tpp_m1_o   <= data_i[DA_W-1:0];
      if (addr_i == CA_W'(REG_OFF))   coef_off_o <= data_i;
      if (addr_i == CA_W'(REG_SCALE)) scale_o    <= data_i[SC_W-1:0];
    end
  end
endmodule

// File: rtl/pp_fir_mem.sv
module pp_fir_mem #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int NTAP = 128,
  parameter int NTPP = 16,
  localparam int CA_W = $clog2(NTAP),
  localparam int DA_W = $clog2(NTPP)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cw_en_i,
  input  logic [CA_W-1:0] cw_addr_i,
  input  logic [CW-1:0]   cw_data_i,
  input  logic            dw_en_i,
  input  logic [DA_W-1:0] dw_addr_i,
  input  logic [DW-1:0]   dw_i_i,
  input  logic [DW-1:0]   dw_q_i,
  input  logic            push_i,
  input  logic [DW-1:0]   push_i_i,
  input  logic [DW-1:0]   push_q_i,
  input  logic [CA_W-1:0] c_raddr_i,
  input  logic [DA_W-1:0] d_back_i,
  output logic [CW-1:0]   coef_o,
  output logic [DW-1:0]   x_i_o,
  output logic [DW-1:0]   x_q_o
);
  logic [CW-1:0]   cmem [NTAP];
  logic [DW-1:0]   dm_i [NTPP];
  logic [DW-1:0]   dm_q [NTPP];
  logic [DA_W-1:0] wp, wp_nx, rd_idx;

  assign wp_nx  = wp + DA_W'(1);
  assign rd_idx = wp - d_back_i;

  // memories carry no reset: contents survive rst_ni
  always_ff @(posedge clk_i) begin
    if (cw_en_i) cmem[cw_addr_i] <= cw_data_i;
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      dm_i[wp_nx] <= push_i_i;
      dm_q[wp_nx] <= push_q_i;
    end else if (dw_en_i) begin
      dm_i[dw_addr_i] <= dw_i_i;
      dm_q[dw_addr_i] <= dw_q_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wp <= '0;
    else if (push_i) wp <= wp_nx;
  end

  assign coef_o = cmem[c_raddr_i];
  assign x_i_o  = dm_i[rd_idx];
  assign x_q_o  = dm_q[rd_idx];
endmodule

// File: rtl/pp_fir_seq.sv
module pp_fir_seq
  import pp_fir_pkg::*;
#(
  parameter int CA_W = 7,
  parameter int DA_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [CA_W-1:0] ntaps_m1_i,
  input  logic [DA_W-1:0] tpp_m1_i,
  input  logic [CA_W-1:0] coef_off_i,
  output logic            ready_o,
  output logic            push_o,
  output logic            mac_en_o,
  output logic            mac_first_o,
  output logic            emit_o,
  output logic [CA_W-1:0] c_raddr_o,
  output logic [DA_W-1:0] d_back_o
);
  fir_state_e      st;
  logic [DA_W-1:0] k;
  logic [CA_W:0]   rel, rel_nx;
  logic            last_phase;

  assign ready_o     = (st == ST_IDLE);
  assign push_o      = ready_o && in_valid_i;
  assign mac_en_o    = (st == ST_MAC);
  assign mac_first_o = (k == '0);
  assign emit_o      = (st == ST_EMIT);
  assign d_back_o    = k;

  // phase base is tracked relative to the offset: no divide by T needed
  assign rel_nx     = rel + (CA_W+1)'(tpp_m1_i) + (CA_W+1)'(1);
  assign last_phase = rel_nx > (CA_W+1)'(ntaps_m1_i);
  assign c_raddr_o  = coef_off_i + rel[CA_W-1:0] + CA_W'(k);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st  <= ST_IDLE;
      k   <= '0;
      rel <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (push_o) begin
            st  <= ST_MAC;
            k   <= '0;
            rel <= '0;
          end
        end
        ST_MAC: begin
          if (k == tpp_m1_i) st <= ST_EMIT;
          else               k  <= k + DA_W'(1);
        end
        ST_EMIT: begin
          k <= '0;
          if (last_phase) begin
            st <= ST_IDLE;
          end else begin
            st  <= ST_MAC;
            rel <= rel_nx;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pp_fir_rail.sv
module pp_fir_rail #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int NTPP = 16,
  parameter int SC_W = 3,
  localparam int ACC_W = DW + CW + $clog2(NTPP),
  localparam int EW    = ACC_W + 1,
  localparam int SH_W  = $clog2(CW) + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mac_en_i,
  input  logic            mac_first_i,
  input  logic            emit_i,
  input  logic [CW-1:0]   coef_i,
  input  logic [DW-1:0]   x_i,
  input  logic [SC_W-1:0] scale_i,
  output logic [DW-1:0]   y_o
);
  localparam logic signed [EW-1:0] Y_MAX = EW'((64'sd1 <<< (DW-1)) - 64'sd1);
  localparam logic signed [EW-1:0] Y_MIN = ~Y_MAX;

  logic signed [DW+CW-1:0] prod;
  logic signed [ACC_W-1:0] acc;
  logic        [SH_W-1:0]  sh_amt;
  logic signed [EW-1:0]    rnd, shifted;
  logic        [DW-1:0]    y_d;

  assign prod = $signed(coef_i) * $signed(x_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc <= '0;
    else if (mac_en_i) acc <= mac_first_i ? ACC_W'(prod) : acc + ACC_W'(prod);
  end

  // coefficients are Q15; scale s cuts the shift from 15 to 15-s
  always_comb begin
    sh_amt  = SH_W'(CW - 1) - SH_W'(scale_i);
    rnd     = EW'(1) <<< (sh_amt - SH_W'(1));
    shifted = (EW'(acc) + rnd) >>> sh_amt;
    if (shifted > Y_MAX)      y_d = Y_MAX[DW-1:0];
    else if (shifted < Y_MIN) y_d = Y_MIN[DW-1:0];
    else                      y_d = shifted[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     y_o <= '0;
    else if (emit_i) y_o <= y_d;
  end
endmodule

// File: rtl/pp_interp_fir.sv
module pp_interp_fir
  import pp_fir_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int NTAP = 128,
  parameter int NTPP = 16,
  parameter int SC_W = 3,
  localparam int CA_W = $clog2(NTAP),
  localparam int DA_W = $clog2(NTPP)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [1:0]      cfg_sel_i,
  input  logic [CA_W-1:0] cfg_addr_i,
  input  logic [2*DW-1:0] cfg_data_i,
  input  logic            in_valid_i,
  input  logic [DW-1:0]   in_i_i,
  input  logic [DW-1:0]   in_q_i,
  output logic            in_ready_o,
  output logic            out_valid_o,
  output logic [DW-1:0]   out_i_o,
  output logic [DW-1:0]   out_q_o
);
  logic [CA_W-1:0] ntaps_m1, coef_off, c_raddr;
  logic [DA_W-1:0] tpp_m1, d_back;
  logic [SC_W-1:0] scale;
  logic            reg_we, coef_we, data_we;
  logic            push, mac_en, mac_first, emit;
  logic [CW-1:0]   coef;
  logic [DW-1:0]   xs [2];
  logic [DW-1:0]   ys [2];

  assign reg_we  = cfg_we_i && (cfg_sel_i == SEL_REG);
  assign coef_we = cfg_we_i && (cfg_sel_i == SEL_COEF);
  assign data_we = cfg_we_i && (cfg_sel_i == SEL_DATA);

  pp_fir_cfg #(.CA_W(CA_W), .DA_W(DA_W), .SC_W(SC_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we),
    .addr_i     (cfg_addr_i),
    .data_i     (cfg_data_i[CA_W-1:0]),
    .ntaps_m1_o (ntaps_m1),
    .tpp_m1_o   (tpp_m1),
    .coef_off_o (coef_off),
    .scale_o    (scale)
  );

  pp_fir_seq #(.CA_W(CA_W), .DA_W(DA_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .ntaps_m1_i  (ntaps_m1),
    .tpp_m1_i    (tpp_m1),
    .coef_off_i  (coef_off),
    .ready_o     (in_ready_o),
    .push_o      (push),
    .mac_en_o    (mac_en),
    .mac_first_o (mac_first),
    .emit_o      (emit),
    .c_raddr_o   (c_raddr),
    .d_back_o    (d_back)
  );

  pp_fir_mem #(.DW(DW), .CW(CW), .NTAP(NTAP), .NTPP(NTPP)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cw_en_i   (coef_we),
    .cw_addr_i (cfg_addr_i),
    .cw_data_i (cfg_data_i[CW-1:0]),
    .dw_en_i   (data_we),
    .dw_addr_i (cfg_addr_i[DA_W-1:0]),
    .dw_i_i    (cfg_data_i[DW-1:0]),
    .dw_q_i    (cfg_data_i[2*DW-1:DW]),
    .push_i    (push),
    .push_i_i  (in_i_i),
    .push_q_i  (in_q_i),
    .c_raddr_i (c_raddr),
    .d_back_i  (d_back),
    .coef_o    (coef),
    .x_i_o     (xs[0]),
    .x_q_o     (xs[1])
  );

  for (genvar r = 0; r < 2; r++) begin : g_rail
    pp_fir_rail #(.DW(DW), .CW(CW), .NTPP(NTPP), .SC_W(SC_W)) u_rail (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .mac_en_i    (mac_en),
      .mac_first_i (mac_first),
      .emit_i      (emit),
      .coef_i      (coef),
      .x_i         (xs[r]),
      .scale_i     (scale),
      .y_o         (ys[r])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_valid_o <= 1'b0;
    else         out_valid_o <= emit;
  end

  assign out_i_o = ys[0];
  assign out_q_o = ys[1];
endmodule

// File: rtl/pp_interp_fir_chk.sv
module pp_interp_fir_chk #(
  parameter int DW   = 16,
  parameter int CA_W = 7,
  parameter int DA_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic            in_ready_o,
  input logic            out_valid_o,
  input logic [DW-1:0]   out_i_o,
  input logic [DW-1:0]   out_q_o,
  input logic [CA_W-1:0] ntaps_m1,
  input logic [DA_W-1:0] tpp_m1
);
  logic [CA_W:0] n_out;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       n_out <= '0;
    else if (in_valid_i && in_ready_o) n_out <= '0;
    else if (out_valid_o)              n_out <= n_out + (CA_W+1)'(1);
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o); // R2

  AST_PHASE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_ready_o) |-> ((int'(n_out) + 1) * (int'(tpp_m1) + 1) == int'(ntaps_m1) + 1)); // R3

  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o); // R8

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> ($stable(out_i_o) && $stable(out_q_o))); // R8

  AST_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && $past(in_ready_o)) |-> !out_valid_o); // R8
endmodule

bind pp_interp_fir pp_interp_fir_chk #(.DW(DW), .CA_W(CA_W), .DA_W(DA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_i_o     (out_i_o),
  .out_q_o     (out_q_o),
  .ntaps_m1    (ntaps_m1),
  .tpp_m1      (tpp_m1)
);

// File: tb/pp_interp_fir_tb.sv
module pp_interp_fir_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [6:0]  cfg_addr = '0;
  logic [31:0] cfg_data = '0;
  logic        in_valid = 1'b0;
  logic [15:0] in_i = '0, in_q = '0;
  logic        in_ready, out_valid;
  logic [15:0] out_i, out_q;

  always #5 clk = ~clk;

  pp_interp_fir u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data), .in_valid_i(in_valid),
    .in_i_i(in_i), .in_q_i(in_q), .in_ready_o(in_ready), .out_valid_o(out_valid),
    .out_i_o(out_i), .out_q_o(out_q)
  );

  int     n_chk = 0, n_fail = 0;
  longint cyc = 0;
  int     coef [128];
  int     hist_i [16], hist_q [16];
  int     c_n = 1, c_t = 1, c_off = 0, c_sc = 0;
  bit     done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(logic [1:0] sel, int addr, logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = 7'(addr); cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_cfg(int n, int t, int off, int sc);
    cfg_write(2'd0, 0, 32'(n - 1));
    cfg_write(2'd0, 1, 32'(t - 1));
    cfg_write(2'd0, 2, 32'(off));
    cfg_write(2'd0, 3, 32'(sc));
    c_n = n; c_t = t; c_off = off; c_sc = sc;
  endtask

  task automatic put_coef(int a, int v);
    coef[a] = v;
    cfg_write(2'd1, a, {16'd0, 16'(v)});
  endtask

  task automatic fill_dmem(int vi, int vq);
    for (int a = 0; a < 16; a++) begin
      cfg_write(2'd2, a, {16'(vq), 16'(vi)});
      hist_i[a] = vi; hist_q[a] = vq;
    end
  endtask

  function automatic int rnd16();
    logic [15:0] r = 16'($urandom());
    return int'($signed(r));
  endfunction

  function automatic longint model(int p, bit q);
    longint acc = 0, r;
    int sh = 15 - c_sc;
    for (int k = 0; k < c_t; k++)
      acc += longint'(coef[(c_off + p * c_t + k) % 128]) * longint'(q ? hist_q[k] : hist_i[k]);
    r = (acc + (longint'(1) <<< (sh - 1))) >>> sh;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic send(int xi, int xq, string req);
    longint a;
    int l = c_n / c_t;
    int got = 0;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    for (int k = 15; k > 0; k--) begin
      hist_i[k] = hist_i[k-1]; hist_q[k] = hist_q[k-1];
    end
    hist_i[0] = xi; hist_q[0] = xq;
    in_valid = 1'b1; in_i = 16'(xi); in_q = 16'(xq);
    @(negedge clk);
    in_valid = 1'b0;
    a = cyc;
    check(!in_ready, "R2", "ready after accept", longint'(in_ready), 0);
    while (got < l) begin
      @(negedge clk);
      if (out_valid) begin
        check(cyc == a + longint'((got + 1) * (c_t + 1)), "R8", "strobe cycle",
              cyc - a, longint'((got + 1) * (c_t + 1)));
        check(int'($signed(out_i)) == model(got, 0), req, "I out",
              longint'($signed(out_i)), model(got, 0));
        check(int'($signed(out_q)) == model(got, 1), req, "Q out",
              longint'($signed(out_q)), model(got, 1));
        got++;
      end
    end
    check(in_ready, "R2", "ready after last out", longint'(in_ready), 1);
  endtask

  task automatic check_reset_state(string tag);
    check(in_ready, "R1", {tag, " ready"}, longint'(in_ready), 1);
    check(!out_valid, "R1", {tag, " valid"}, longint'(out_valid), 0);
    check(out_i == 16'd0 && out_q == 16'd0, "R1", {tag, " data"}, longint'({out_i, out_q}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check_reset_state("in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state("after reset");

    // R3 R9: random filter, L=2
    fill_dmem(0, 0);
    for (int a = 0; a < 128; a++) put_coef(a, rnd16());
    set_cfg(8, 4, 0, 0);
    for (int i = 0; i < 6; i++) send(rnd16(), rnd16(), "R3");
    // R9: I only, Q zero history
    fill_dmem(0, 0);
    for (int i = 0; i < 3; i++) send(rnd16(), 0, "R9");

    // single tap, no interpolation
    set_cfg(1, 1, 5, 3);
    for (int i = 0; i < 3; i++) send(rnd16(), rnd16(), "R3");

    // full 16-deep history
    set_cfg(16, 16, 0, 7);
    for (int i = 0; i < 20; i++) send(rnd16(), rnd16(), "R5");

    // maximum interpolation
    set_cfg(128, 1, 0, 2);
    for (int i = 0; i < 2; i++) send(rnd16(), rnd16(), "R3");

    // R4: offset with wrap, then another filter
    set_cfg(16, 4, 120, 1);
    for (int i = 0; i < 4; i++) send(rnd16(), rnd16(), "R4");
    set_cfg(16, 4, 40, 1);
    for (int i = 0; i < 4; i++) send(rnd16(), rnd16(), "R4");

    // R6: scale sweep
    for (int s = 0; s < 8; s++) begin
      set_cfg(12, 3, 7, s);
      for (int i = 0; i < 2; i++) send(rnd16(), rnd16(), "R6");
    end
    // R6: exact half rounds up (s=0: acc 16384 -> 1, acc -16384 -> 0)
    put_coef(0, 16384);
    set_cfg(1, 1, 0, 0);
    send(1, -1, "R6");

    // R7: saturation both ways
    for (int a = 0; a < 16; a++) put_coef(a, 32767);
    set_cfg(16, 16, 0, 7);
    fill_dmem(0, 0);
    for (int i = 0; i < 16; i++) send(32767, -32768, "R7");
    check(int'($signed(out_i)) == 32767, "R7", "positive clip", longint'($signed(out_i)), 32767);
    check(int'($signed(out_q)) == -32768, "R7", "negative clip", longint'($signed(out_q)), -32768);

    // R5: reset keeps both memories
    fill_dmem(1000, -2000);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check_reset_state("mid reset");
    rst_n = 1'b1;
    c_n = 1; c_t = 1; c_off = 0; c_sc = 0;
    send(3, 5, "R1");
    set_cfg(4, 4, 0, 7);
    send(rnd16(), rnd16(), "R5");

    // random configurations
    for (int it = 0; it < 12; it++) begin
      int t = 1 + int'($urandom() % 16);
      int lmax = 128 / t;
      int l;
      if (lmax > 8) lmax = 8;
      l = 1 + int'($urandom() % lmax);
      for (int a = 0; a < 4; a++) put_coef(int'($urandom() % 128), rnd16());
      set_cfg(t * l, t, int'($urandom() % 128), int'($urandom() % 8));
      for (int i = 0; i < 3; i++) send(rnd16(), rnd16(), "R3");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule